// File: doc/BRIEF.md
# Program ROM Bank Selector

This block steers instruction fetches across three program ROMs that share one 8-bit data bus. A fixed boot ROM carries a normal lower page and a diagnostic upper page. Two switchable ROMs, called A and B here, each carry a lower and an upper page. The low ten program address lines go to every ROM in parallel. The top address line picks between the boot ROM and the switchable pair. The block produces one output enable per ROM page. At most one enable is high at a time, so only one page can drive the bus.

Software picks a switchable ROM and page by writing two data bits to a small select register. The write goes through a decoded device-select code. Once the write is done, the register keeps its value and the bus is free for other traffic. Pulling the top address line low sends fetches back to the boot ROM's lower page. The select register is not changed by this, so raising the line again restores the earlier choice. A pair of strap pins picks normal operation, diagnostic-only operation, or no ROM output at all.

Top module: `prog_rom_bank_sel`

## Requirements
- R1: `rom_addr` always equals `prog_addr[9:0]`, with no register in the path.
- R2: A synchronous active-high `rst` clears the select register to 0 (ROM B, lower page). After reset, with `prog_addr[10]` low and straps `00`, only `oe_boot_lo` is high.
- R3: The select register loads `bus_sel` on a rising `clk` edge only when `rd_wr` is 1 (write) and `dev_sel` equals 5. Bit 0 selects the page (1 = upper, 0 = lower). Bit 1 selects the ROM (1 = ROM A, 0 = ROM B).
- R4: A `dev_sel` other than 5, or `rd_wr` at 0, leaves the select register unchanged.
- R5: With straps `00`, `prog_addr[10]` high and `src_gate` high, exactly the enable of the selected ROM and page is high.
- R6: With `src_gate` low, no enable of ROM A or ROM B is high.
- R7: With straps `00` and `prog_addr[10]` low, only `oe_boot_lo` is high. The select register keeps its value, so raising `prog_addr[10]` again restores the previous selection.
- R8: With straps `00`, `oe_boot_hi` is never high.
- R9: With straps `01`, only `oe_boot_hi` can be high, and it is high exactly when `prog_addr[10]` is low.
- R10: With straps `10` or `11`, all six enables are low.
- R11: At most one of the six enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | input | 11 | Program address; bit 10 chooses boot (0) or switchable (1) ROMs |
| dev_sel | input | 4 | Device-select code from the processor |
| rd_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 2 | Data bus bits 0 (page) and 1 (ROM) |
| src_gate | input | 1 | Program-source gate; qualifies the switchable ROMs |
| strap | input | 2 | 00 normal, 01 diagnostic only, 10/11 all disabled |
| rom_addr | output | 10 | Address shared by all ROMs |
| oe_boot_lo | output | 1 | Boot ROM lower page enable |
| oe_boot_hi | output | 1 | Boot ROM upper (diagnostic) page enable |
| oe_a_lo | output | 1 | ROM A lower page enable |
| oe_a_hi | output | 1 | ROM A upper page enable |
| oe_b_lo | output | 1 | ROM B lower page enable |
| oe_b_hi | output | 1 | ROM B upper page enable |

## Verification
The bench tries a write with every device code and both read/write values. A decoder that accepted a neighbouring code, or that ignored the write direction, would change the selection and show the wrong enable. It then covers every combination of the four stored selections with each strap code, address-line value and gate value. This catches swapped page or ROM bits, a diagnostic page that leaks into normal mode, a switchable ROM that drives while the gate is low, and a strap code 11 that is treated as normal. A return to the boot ROM followed by going back up shows whether the register was wrongly cleared in between.

// File: rtl/prog_rom_bank_sel.sv
module prog_rom_bank_sel #(
  parameter int ADDR_W   = 11,
  parameter int DEV_W    = 4,
  parameter int DEV_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DEV_W-1:0]  dev_sel,
  input  logic              rd_wr,
  input  logic [1:0]        bus_sel,
  input  logic              src_gate,
  input  logic [1:0]        strap,
  output logic [ADDR_W-2:0] rom_addr,
  output logic              oe_boot_lo,
  output logic              oe_boot_hi,
  output logic              oe_a_lo,
  output logic              oe_a_hi,
  output logic              oe_b_lo,
  output logic              oe_b_hi
);
  localparam int BANK_BIT = ADDR_W - 1;

  logic [1:0] sel_q;
  logic       wr_stb, hi_bank, m_norm, m_test, bank_on;

  assign wr_stb  = rd_wr && (dev_sel == DEV_W'(DEV_CODE));
  assign hi_bank = prog_addr[BANK_BIT];
  assign m_norm  = (strap == 2'b00);
  assign m_test  = (strap == 2'b01);
  assign bank_on = m_norm & hi_bank & src_gate;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= 2'b00;
    else if (wr_stb) sel_q <= bus_sel;
  end

  assign rom_addr   = prog_addr[BANK_BIT-1:0];
  assign oe_boot_lo = m_norm & ~hi_bank;
  assign oe_boot_hi = m_test & ~hi_bank;
  assign oe_a_lo    = bank_on &  sel_q[1] & ~sel_q[0];
  assign oe_a_hi    = bank_on &  sel_q[1] &  sel_q[0];
  assign oe_b_lo    = bank_on & ~sel_q[1] & ~sel_q[0];
  assign oe_b_hi    = bank_on & ~sel_q[1] &  sel_q[0];

  logic [5:0] oe_vec;
  assign oe_vec = {oe_boot_lo, oe_boot_hi, oe_a_lo, oe_a_hi, oe_b_lo, oe_b_hi};

  // R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> sel_q == $past(bus_sel));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(sel_q));

  // R11
  one_drv_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(oe_vec));

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !src_gate |-> !(oe_a_lo | oe_a_hi | oe_b_lo | oe_b_hi));

  // R8
  no_diag_chk: assert property (@(posedge clk) disable iff (rst)
    (strap == 2'b00) |-> !oe_boot_hi);

  // R10
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    strap[1] |-> (oe_vec == 6'b0));

  // R9
  test_only_chk: assert property (@(posedge clk) disable iff (rst)
    (strap == 2'b01) |-> (oe_vec == {1'b0, !prog_addr[BANK_BIT], 4'b0}));
endmodule

// File: tb/test_prog_rom_bank_sel.sv
`timescale 1ns/1ps
module test_prog_rom_bank_sel;
  logic        clk = 0, rst = 1;
  logic [10:0] prog_addr = 0;
  logic [3:0]  dev_sel = 0;
  logic        rd_wr = 0, src_gate = 0;
  logic [1:0]  bus_sel = 0, strap = 0;
  logic [9:0]  rom_addr;
  logic        oe_boot_lo, oe_boot_hi, oe_a_lo, oe_a_hi, oe_b_lo, oe_b_hi;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  prog_rom_bank_sel i_prog_rom_bank_sel (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .dev_sel(dev_sel), .rd_wr(rd_wr),
    .bus_sel(bus_sel), .src_gate(src_gate), .strap(strap), .rom_addr(rom_addr),
    .oe_boot_lo(oe_boot_lo), .oe_boot_hi(oe_boot_hi), .oe_a_lo(oe_a_lo),
    .oe_a_hi(oe_a_hi), .oe_b_lo(oe_b_lo), .oe_b_hi(oe_b_hi));

  function automatic logic [5:0] oe_now();
    return {oe_boot_lo, oe_boot_hi, oe_a_lo, oe_a_hi, oe_b_lo, oe_b_hi};
  endfunction

  // bit 5 boot_lo, 4 boot_hi, 3 a_lo, 2 a_hi, 1 b_lo, 0 b_hi
  function automatic logic [5:0] oe_exp(input int st, input int a10, input int g, input int r);
    int idx;
    if (st != 0) return (st == 1 && a10 == 0) ? 6'b010000 : 6'b0;
    if (a10 == 0) return 6'b100000;
    if (g == 0) return 6'b0;
    idx = (r / 2 == 1) ? (3 - r % 2) : (1 - r % 2);
    return 6'(1 << idx);
  endfunction

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic load(input int v);
    @(negedge clk);
    dev_sel = 4'd5; rd_wr = 1; bus_sel = 2'(v);
    @(negedge clk);
    dev_sel = 0; rd_wr = 0; bus_sel = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R2", {4'b0, oe_now()}, {4'b0, 6'b100000});
    prog_addr = 11'h400; src_gate = 1;
    #1 check("R2", {4'b0, oe_now()}, {4'b0, oe_exp(0, 1, 1, 0)});

    for (int a = 0; a < 2048; a++) begin
      prog_addr = 11'(a);
      #0.1 check("R1", rom_addr, 10'(a));
    end

    prog_addr = 11'h400; src_gate = 1; strap = 0;
    for (int d = 0; d < 16; d++)
      for (int w = 0; w < 2; w++) begin
        int v0, v1, ex;
        v0 = (d + w) % 4; v1 = 3 - v0;
        load(v0);
        dev_sel = 4'(d); rd_wr = w[0]; bus_sel = 2'(v1);
        @(negedge clk);
        dev_sel = 0; rd_wr = 0; bus_sel = 0;
        #1;
        ex = (w == 1 && d == 5) ? v1 : v0;
        if (ex == v1) check("R3", {4'b0, oe_now()}, {4'b0, oe_exp(0, 1, 1, ex)});
        else          check("R4", {4'b0, oe_now()}, {4'b0, oe_exp(0, 1, 1, ex)});
      end

    for (int r = 0; r < 4; r++) begin
      load(r);
      for (int st = 0; st < 4; st++)
        for (int a10 = 0; a10 < 2; a10++)
          for (int g = 0; g < 2; g++) begin
            logic [5:0] o;
            string tag;
            strap = 2'(st); prog_addr = {a10[0], 10'h155}; src_gate = g[0];
            #1 o = oe_now();
            if (st >= 2)        tag = "R10";
            else if (st == 1)   tag = "R9";
            else if (a10 == 0)  tag = "R7";
            else if (g == 0)    tag = "R6";
            else                tag = "R5";
            check(tag, {4'b0, o}, {4'b0, oe_exp(st, a10, g, r)});
            check("R11", 10'($countones(o) <= 1), 10'd1);
            if (st == 0) check("R8", {9'b0, o[4]}, 10'd0);
          end
    end

    strap = 0; src_gate = 1;
    load(3);
    prog_addr = 11'h000;
    repeat (3) @(negedge clk);
    check("R7", {4'b0, oe_now()}, {4'b0, 6'b100000});
    prog_addr = 11'h400;
    #1 check("R7", {4'b0, oe_now()}, {4'b0, oe_exp(0, 1, 1, 3)});

    rst = 1;
    @(negedge clk);
    rst = 0;
    #1 check("R2", {4'b0, oe_now()}, {4'b0, oe_exp(0, 1, 1, 0)});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule